// File: doc/BRIEF.md
# Test Access Port Controller with Configuration Load

This block is the scan-test front end of a programmable device. All of its logic runs on the test clock `tck`. A `tms` pin steers it through the sixteen-state test-port sequence, serial data enters on `tdi` and leaves on `tdo`. A five-bit instruction picks which data path sits between `tdi` and `tdo`. The paths are a one-bit bypass stage, a 32-bit device identifier, a 32-bit user code, a short stub for the boundary cell chain, or one of two scan chains built in the user's own logic.

The block also loads the device from the same four pins. With the configuration-input instruction active, each bit shifted in on `tdi` appears on `cfg_bit` with `cfg_valid` one cycle later, for the configuration memory to take in. Loading the start instruction and entering Run-Test/Idle gives a one-cycle `dev_start` pulse. A third instruction asks the pad ring to float every output.

The user chains get a select line each, a clock enable each, and state strobes that they share. The user logic gates `tck` with its enable and returns its serial output on `usr1_tdo` or `usr2_tdo`.

Top module: `scanport_ctrl`

## Requirements
- R1: The controller follows the standard test-port state graph on each rising `tck` edge. Five consecutive cycles with `tms`=1 reach Test-Logic-Reset from any state. A high `rst` at a rising edge also forces Test-Logic-Reset.
- R2: The instruction register is 5 bits wide. It takes IDCODE (01001) on `rst` and on every edge spent in Test-Logic-Reset. In Capture-IR it loads 00001, and Shift-IR shifts it out least significant bit first.
- R3: Instruction 01001 selects a 32-bit identifier. Bits 31:28 hold the version, 27:21 the family, 20:12 the array size, 11:1 the maker, and bit 0 is 1. With the default parameters it reads 32'h0061_0093, shifted out LSB first.
- R4: Instruction 11111, and every code with no function below, selects a one-bit bypass stage. This covers 00100, 00110 and 10110. The stage captures 0, so the bits leave delayed by one cycle.
- R5: Instruction 01000 selects a 32-bit register that captures the USER_CODE parameter (default 32'hC0DE_5A17).
- R6: With 00010 loaded, `usr1_sel` is high and `tdo` is taken from `usr1_tdo`. With 00011 loaded, `usr2_sel` is high and `tdo` is taken from `usr2_tdo`. The matching clock enable is high in Capture-DR and Shift-DR only.
- R7: `usr_reset`, `usr_capture`, `usr_shift` and `usr_update` are high exactly while the controller is in Test-Logic-Reset, Capture-DR, Shift-DR and Update-DR respectively.
- R8: With 00101 loaded, each rising edge spent in Shift-DR raises `cfg_valid` for the next cycle. `cfg_bit` then carries the `tdi` value of that edge.
- R9: With 01100 loaded, `dev_start` is high for exactly the first cycle of each stay in Run-Test/Idle.
- R10: With 01010 loaded, `io_hiz` is high and the bypass stage is the data path.
- R11: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR; a low `tdo_oe` means the pin floats.
- R12: Instructions 00000, 00001 and 00111 select a stub of BSR_LEN bits (default 8) that captures zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edges |
| tdo_oe | output | 1 | Output enable for the tdo pad |
| usr1_sel | output | 1 | User chain 1 selected |
| usr2_sel | output | 1 | User chain 2 selected |
| usr1_tdo | input | 1 | Serial return from user chain 1 |
| usr2_tdo | input | 1 | Serial return from user chain 2 |
| usr1_ck_en | output | 1 | Clock enable for user chain 1 |
| usr2_ck_en | output | 1 | Clock enable for user chain 2 |
| usr_tdi | output | 1 | Serial data to user chains |
| usr_reset | output | 1 | Test-Logic-Reset indication |
| usr_capture | output | 1 | Capture-DR indication |
| usr_shift | output | 1 | Shift-DR indication |
| usr_update | output | 1 | Update-DR indication |
| cfg_bit | output | 1 | Configuration data bit |
| cfg_valid | output | 1 | Configuration bit valid |
| dev_start | output | 1 | Device start-up pulse |
| io_hiz | output | 1 | Float all device outputs |

## Verification
A wrong controller state shows on the state strobes within the same cycle and on `tdo_oe` half a cycle later. The bench compares both against its own state model every cycle. A wrong instruction decode shows at once on the select, float and start outputs. It also shows in the first serial bit after the next Capture-DR, because every path has its own capture value or source pin. A corrupted shift register shows up bit by bit in the serial stream and in the collected identifier, user code and configuration words.

// File: rtl/scanport_pkg.sv
package scanport_pkg;
  localparam int IR_W = 5;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PA_DR, TS_EX2_DR, TS_UP_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PA_IR, TS_EX2_IR, TS_UP_IR
  } tap_st_t;

  typedef enum logic [2:0] {
    PATH_BYP, PATH_ID, PATH_UC, PATH_BSR, PATH_U1, PATH_U2
  } dpath_t;

  localparam logic [IR_W-1:0] OP_EXTEST = 5'b00000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 5'b00001;
  localparam logic [IR_W-1:0] OP_USER1  = 5'b00010;
  localparam logic [IR_W-1:0] OP_USER2  = 5'b00011;
  localparam logic [IR_W-1:0] OP_CFGIN  = 5'b00101;
  localparam logic [IR_W-1:0] OP_INTEST = 5'b00111;
  localparam logic [IR_W-1:0] OP_UCODE  = 5'b01000;
  localparam logic [IR_W-1:0] OP_IDCODE = 5'b01001;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 5'b01010;
  localparam logic [IR_W-1:0] OP_JSTART = 5'b01100;
  localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

  function automatic tap_st_t tap_next(tap_st_t s, logic m);
    case (s)
      TS_RESET:  return m ? TS_RESET  : TS_IDLE;
      TS_IDLE:   return m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: return m ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: return m ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  return m ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: return m ? TS_UP_DR  : TS_PA_DR;
      TS_PA_DR:  return m ? TS_EX2_DR : TS_PA_DR;
      TS_EX2_DR: return m ? TS_UP_DR  : TS_SH_DR;
      TS_UP_DR:  return m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: return m ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: return m ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  return m ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: return m ? TS_UP_IR  : TS_PA_IR;
      TS_PA_IR:  return m ? TS_EX2_IR : TS_PA_IR;
      TS_EX2_IR: return m ? TS_UP_IR  : TS_SH_IR;
      default:   return m ? TS_SEL_DR : TS_IDLE;
    endcase
  endfunction

  // Unlisted codes, including the readback code, fall back to bypass.
  function automatic dpath_t path_of(logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPLE, OP_INTEST: return PATH_BSR;
      OP_USER1:  return PATH_U1;
      OP_USER2:  return PATH_U2;
      OP_UCODE:  return PATH_UC;
      OP_IDCODE: return PATH_ID;
      default:   return PATH_BYP;
    endcase
  endfunction
endpackage

// File: rtl/scanport_fsm.sv
module scanport_fsm
  import scanport_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tms,
  output logic f_reset,
  output logic f_idle_entry,
  output logic f_cap_dr,
  output logic f_sh_dr,
  output logic f_up_dr,
  output logic f_cap_ir,
  output logic f_sh_ir,
  output logic f_up_ir
);
  tap_st_t st, nxt;

  always_comb nxt = tap_next(st, tms);

  // Each flag is registered from the next state, so it equals (st == X).
  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= TS_RESET;
      f_reset      <= 1'b1;
      f_idle_entry <= 1'b0;
      f_cap_dr     <= 1'b0;
      f_sh_dr      <= 1'b0;
      f_up_dr      <= 1'b0;
      f_cap_ir     <= 1'b0;
      f_sh_ir      <= 1'b0;
      f_up_ir      <= 1'b0;
    end else begin
      st           <= nxt;
      f_reset      <= (nxt == TS_RESET);
      f_idle_entry <= (nxt == TS_IDLE) && (st != TS_IDLE);
      f_cap_dr     <= (nxt == TS_CAP_DR);
      f_sh_dr      <= (nxt == TS_SH_DR);
      f_up_dr      <= (nxt == TS_UP_DR);
      f_cap_ir     <= (nxt == TS_CAP_IR);
      f_sh_ir      <= (nxt == TS_SH_IR);
      f_up_ir      <= (nxt == TS_UP_IR);
    end
  end

  // R1
  five_ones_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> f_reset);

  // R1
  upir_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (f_up_ir && !tms) |=> f_idle_entry);

  // R7
  capdr_to_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (f_cap_dr && !tms) |=> f_sh_dr);
endmodule

// File: rtl/scanport_ir.sv
module scanport_ir
  import scanport_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tdi,
  input  logic   f_reset,
  input  logic   f_cap_ir,
  input  logic   f_sh_ir,
  input  logic   f_up_ir,
  output logic   sh_lsb,
  output dpath_t path,
  output logic   sel1,
  output logic   sel2,
  output logic   hiz,
  output logic   cfg_in,
  output logic   jstart
);
  logic [IR_W-1:0] ir_sh, ir_q, ir_nxt;

  always_comb begin
    ir_nxt = ir_q;
    if (f_reset)      ir_nxt = OP_IDCODE;
    else if (f_up_ir) ir_nxt = ir_sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_sh  <= IR_CAPTURE;
      ir_q   <= OP_IDCODE;
      path   <= PATH_ID;
      sel1   <= 1'b0;
      sel2   <= 1'b0;
      hiz    <= 1'b0;
      cfg_in <= 1'b0;
      jstart <= 1'b0;
    end else begin
      if (f_cap_ir)     ir_sh <= IR_CAPTURE;
      else if (f_sh_ir) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
      ir_q   <= ir_nxt;
      path   <= path_of(ir_nxt);
      sel1   <= (ir_nxt == OP_USER1);
      sel2   <= (ir_nxt == OP_USER2);
      hiz    <= (ir_nxt == OP_HIGHZ);
      cfg_in <= (ir_nxt == OP_CFGIN);
      jstart <= (ir_nxt == OP_JSTART);
    end
  end

  assign sh_lsb = ir_sh[0];

  // R2
  ir_capture_chk: assert property (@(posedge clk) disable iff (rst)
    f_cap_ir |=> (ir_sh == IR_CAPTURE));

  // R2
  reset_loads_id_chk: assert property (@(posedge clk) disable iff (rst)
    f_reset |=> (path == PATH_ID));

  // R10
  hiz_uses_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    hiz |-> (path == PATH_BYP));
endmodule

// File: rtl/scanport_dr.sv
module scanport_dr
  import scanport_pkg::*;
#(
  parameter logic [31:0] ID_VALUE  = 32'h0000_0001,
  parameter logic [31:0] USER_CODE = 32'h0000_0000,
  parameter int          BSR_LEN   = 8   // 1..32
)
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tdi,
  input  dpath_t path,
  input  logic   f_cap_dr,
  input  logic   f_sh_dr,
  output logic   dr_lsb
);
  localparam int DR_W  = 32;
  localparam int IDX_W = $clog2(DR_W);
  localparam logic [IDX_W-1:0] BSR_TOP = IDX_W'(BSR_LEN - 1);
  localparam logic [IDX_W-1:0] WORD_TOP = IDX_W'(DR_W - 1);

  logic [DR_W-1:0]  dr_sh, shifted, cap_val;
  logic [IDX_W-1:0] top_idx;

  always_comb begin
    case (path)
      PATH_ID, PATH_UC: top_idx = WORD_TOP;
      PATH_BSR:         top_idx = BSR_TOP;
      default:          top_idx = '0;
    endcase
  end

  always_comb begin
    case (path)
      PATH_ID: cap_val = ID_VALUE;
      PATH_UC: cap_val = USER_CODE;
      default: cap_val = '0;
    endcase
  end

  always_comb begin
    shifted          = dr_sh >> 1;
    shifted[top_idx] = tdi;
  end

  always_ff @(posedge clk) begin
    if (rst)           dr_sh <= '0;
    else if (f_cap_dr) dr_sh <= cap_val;
    else if (f_sh_dr)  dr_sh <= shifted;
  end

  assign dr_lsb = dr_sh[0];

  // R4
  bypass_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (f_cap_dr && path == PATH_BYP) |=> !dr_lsb);

  // R3
  id_lsb_one_chk: assert property (@(posedge clk) disable iff (rst)
    (f_cap_dr && path == PATH_ID) |=> dr_lsb);
endmodule

// File: rtl/scanport_ctrl.sv
module scanport_ctrl
  import scanport_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h0,
  parameter logic [6:0]  ID_FAMILY  = 7'h03,
  parameter logic [8:0]  ID_ARRAY   = 9'h010,
  parameter logic [10:0] ID_MAKER   = 11'h049,
  parameter logic [31:0] USER_CODE  = 32'hC0DE_5A17,
  parameter int          BSR_LEN    = 8
)
(
  input  logic tck,
  input  logic rst,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_oe,
  output logic usr1_sel,
  output logic usr2_sel,
  input  logic usr1_tdo,
  input  logic usr2_tdo,
  output logic usr1_ck_en,
  output logic usr2_ck_en,
  output logic usr_tdi,
  output logic usr_reset,
  output logic usr_capture,
  output logic usr_shift,
  output logic usr_update,
  output logic cfg_bit,
  output logic cfg_valid,
  output logic dev_start,
  output logic io_hiz
);
  localparam logic [31:0] ID_VALUE = {ID_VERSION, ID_FAMILY, ID_ARRAY, ID_MAKER, 1'b1};

  logic   f_reset, f_idle_entry, f_cap_dr, f_sh_dr, f_up_dr, f_cap_ir, f_sh_ir, f_up_ir;
  logic   ir_lsb, dr_lsb, cfg_in, jstart, dr_out;
  dpath_t path;

  scanport_fsm u_fsm (
    .clk(tck), .rst(rst), .tms(tms),
    .f_reset(f_reset), .f_idle_entry(f_idle_entry),
    .f_cap_dr(f_cap_dr), .f_sh_dr(f_sh_dr), .f_up_dr(f_up_dr),
    .f_cap_ir(f_cap_ir), .f_sh_ir(f_sh_ir), .f_up_ir(f_up_ir)
  );

  scanport_ir u_ir (
    .clk(tck), .rst(rst), .tdi(tdi),
    .f_reset(f_reset), .f_cap_ir(f_cap_ir), .f_sh_ir(f_sh_ir), .f_up_ir(f_up_ir),
    .sh_lsb(ir_lsb), .path(path), .sel1(usr1_sel), .sel2(usr2_sel),
    .hiz(io_hiz), .cfg_in(cfg_in), .jstart(jstart)
  );

  scanport_dr #(.ID_VALUE(ID_VALUE), .USER_CODE(USER_CODE), .BSR_LEN(BSR_LEN)) u_dr (
    .clk(tck), .rst(rst), .tdi(tdi), .path(path),
    .f_cap_dr(f_cap_dr), .f_sh_dr(f_sh_dr), .dr_lsb(dr_lsb)
  );

  always_comb begin
    case (path)
      PATH_U1: dr_out = usr1_tdo;
      PATH_U2: dr_out = usr2_tdo;
      default: dr_out = dr_lsb;
    endcase
  end

  // Serial output moves on the falling edge, half a cycle before the shift.
  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= f_sh_ir | f_sh_dr;
      tdo    <= f_sh_ir ? ir_lsb : dr_out;
    end
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      cfg_valid <= 1'b0;
      cfg_bit   <= 1'b0;
    end else begin
      cfg_valid <= f_sh_dr & cfg_in;
      if (f_sh_dr & cfg_in) cfg_bit <= tdi;
    end
  end

  assign dev_start   = f_idle_entry & jstart;
  assign usr_tdi     = tdi;
  assign usr_reset   = f_reset;
  assign usr_capture = f_cap_dr;
  assign usr_shift   = f_sh_dr;
  assign usr_update  = f_up_dr;
  assign usr1_ck_en  = usr1_sel & (f_cap_dr | f_sh_dr);
  assign usr2_ck_en  = usr2_sel & (f_cap_dr | f_sh_dr);

  // R8
  cfg_follow_chk: assert property (@(posedge tck) disable iff (rst)
    cfg_valid |-> ($past(f_sh_dr) && $past(cfg_in)));

  // R9
  start_once_chk: assert property (@(posedge tck) disable iff (rst)
    dev_start |=> !dev_start);

  // R11
  oe_on_shift_chk: assert property (@(negedge tck) disable iff (rst)
    (f_sh_dr || f_sh_ir) |=> tdo_oe);

  // R11
  oe_off_chk: assert property (@(negedge tck) disable iff (rst)
    !(f_sh_dr || f_sh_ir) |=> !tdo_oe);

  // R6
  mode_mutex_chk: assert property (@(posedge tck) disable iff (rst)
    $onehot0({usr1_sel, usr2_sel, io_hiz, cfg_in, jstart}));
endmodule

// File: tb/scanport_ctrl_tb.sv
module scanport_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EXP_ID = 32'h0061_0093;
  localparam logic [31:0] EXP_UC = 32'hC0DE_5A17;
  localparam int BSR = 8;

  // model state numbering (bench-local)
  localparam int M_TLR = 0, M_RTI = 1, M_SDR = 2, M_CDR = 3, M_SHD = 4, M_E1D = 5,
                 M_PD = 6, M_E2D = 7, M_UDR = 8, M_SIR = 9, M_CIR = 10, M_SHI = 11,
                 M_E1I = 12, M_PI = 13, M_E2I = 14, M_UIR = 15;

  logic tck = 0, rst = 1, tms = 1, tdi = 0;
  logic usr1_tdo = 1, usr2_tdo = 0;
  logic tdo, tdo_oe, usr1_sel, usr2_sel, usr1_ck_en, usr2_ck_en, usr_tdi;
  logic usr_reset, usr_capture, usr_shift, usr_update, cfg_bit, cfg_valid, dev_start, io_hiz;

  int n_chk = 0, n_fail = 0;
  int ms = M_TLR, mir = 9, mirsh = 1;
  bit mq[$];
  bit m_cfgv = 0, m_cfgb = 0, m_start = 0;
  logic [31:0] obs = 0, cfg_acc = 0;
  int cfg_cnt = 0, start_cnt = 0;

  always #(CLK_PERIOD/2) tck = ~tck;

  scanport_ctrl u_dut (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .usr1_sel(usr1_sel), .usr2_sel(usr2_sel), .usr1_tdo(usr1_tdo), .usr2_tdo(usr2_tdo),
    .usr1_ck_en(usr1_ck_en), .usr2_ck_en(usr2_ck_en), .usr_tdi(usr_tdi),
    .usr_reset(usr_reset), .usr_capture(usr_capture), .usr_shift(usr_shift),
    .usr_update(usr_update), .cfg_bit(cfg_bit), .cfg_valid(cfg_valid),
    .dev_start(dev_start), .io_hiz(io_hiz)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nstate(int s, bit m);
    if (s == M_TLR) return m ? M_TLR : M_RTI;
    if (s == M_RTI || s == M_UDR || s == M_UIR) return m ? M_SDR : M_RTI;
    if (s == M_SDR) return m ? M_SIR : M_CDR;
    if (s == M_SIR) return m ? M_TLR : M_CIR;
    if (s == M_CDR || s == M_SHD) return m ? M_E1D : M_SHD;
    if (s == M_E1D) return m ? M_UDR : M_PD;
    if (s == M_PD) return m ? M_E2D : M_PD;
    if (s == M_E2D) return m ? M_UDR : M_SHD;
    if (s == M_CIR || s == M_SHI) return m ? M_E1I : M_SHI;
    if (s == M_E1I) return m ? M_UIR : M_PI;
    if (s == M_PI) return m ? M_E2I : M_PI;
    return m ? M_UIR : M_SHI;
  endfunction

  // 0 bypass, 1 id, 2 usercode, 3 stub, 4 user1, 5 user2
  function automatic int mpath(int ir);
    case (ir)
      0, 1, 7: return 3;
      2: return 4;
      3: return 5;
      8: return 2;
      9: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic model_edge(input bit m, input bit d);
    int s = ms;
    int p = mpath(mir);
    m_cfgv = 0;
    m_start = 0;
    if (rst) begin
      ms = M_TLR; mir = 9; mirsh = 1; mq.delete();
      return;
    end
    m_cfgv = (s == M_SHD) && (mir == 5);
    if (m_cfgv) m_cfgb = d;
    if (s == M_CIR) mirsh = 1;
    else if (s == M_SHI) mirsh = (mirsh >> 1) | (int'(d) << 4);
    if (s == M_UIR) mir = mirsh;
    if (s == M_TLR) mir = 9;
    if (s == M_CDR) begin
      mq.delete();
      if (p == 0) mq.push_back(0);
      else if (p == 1) for (int i = 0; i < 32; i++) mq.push_back(EXP_ID[i]);
      else if (p == 2) for (int i = 0; i < 32; i++) mq.push_back(EXP_UC[i]);
      else if (p == 3) for (int i = 0; i < BSR; i++) mq.push_back(0);
    end else if (s == M_SHD && mq.size() > 0) begin
      void'(mq.pop_front());
      mq.push_back(d);
    end
    ms = nstate(s, m);
    m_start = (ms == M_RTI) && (s != M_RTI) && (mir == 12);
  endtask

  task automatic check_pos();
    chk("R7 usr_reset", usr_reset, ms == M_TLR);
    chk("R7 usr_capture", usr_capture, ms == M_CDR);
    chk("R7 usr_shift", usr_shift, ms == M_SHD);
    chk("R7 usr_update", usr_update, ms == M_UDR);
    chk("R6 usr1_sel", usr1_sel, mir == 2);
    chk("R6 usr2_sel", usr2_sel, mir == 3);
    chk("R6 usr1_ck_en", usr1_ck_en, (mir == 2) && (ms == M_CDR || ms == M_SHD));
    chk("R6 usr2_ck_en", usr2_ck_en, (mir == 3) && (ms == M_CDR || ms == M_SHD));
    chk("R10 io_hiz", io_hiz, mir == 10);
    chk("R8 cfg_valid", cfg_valid, m_cfgv);
    if (m_cfgv) chk("R8 cfg_bit", cfg_bit, m_cfgb);
    chk("R9 dev_start", dev_start, m_start);
    if (cfg_valid) begin cfg_acc = {cfg_bit, cfg_acc[31:1]}; cfg_cnt++; end
    if (dev_start) start_cnt++;
  endtask

  task automatic check_neg();
    bit oe = (ms == M_SHI) || (ms == M_SHD);
    bit exp;
    chk("R11 tdo_oe", tdo_oe, oe);
    if (oe) begin
      if (ms == M_SHI) exp = mirsh[0];
      else if (mpath(mir) == 4) exp = usr1_tdo;
      else if (mpath(mir) == 5) exp = usr2_tdo;
      else exp = (mq.size() > 0) ? mq[0] : 1'b0;
      chk("R11 tdo", tdo, exp);
      obs = {tdo, obs[31:1]};
    end
  endtask

  task automatic step(input bit m, input bit d);
    tms = m; tdi = d;
    @(posedge tck);
    model_edge(m, d);
    #(CLK_PERIOD/4);
    check_pos();
    @(negedge tck);
    #(CLK_PERIOD/8);
    check_neg();
  endtask

  task automatic load_ir(input logic [4:0] op);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(i == 4, op[i]);
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] pat);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) step(i == n - 1, pat[i]);
    step(1, 0); step(0, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    @(negedge tck);
    step(1, 0); step(1, 0);
    rst = 0;
    chk("R1 reset state", usr_reset, 1'b1);
    step(0, 0);
    // R3 identifier selected after reset (R2)
    scan_dr(32, 32'h0);
    chk("R3 idcode word", obs, EXP_ID);
    // R2 capture pattern, R4 bypass
    load_ir(5'b11111);
    chk("R2 ir capture", obs[31:27], 5'b00001);
    scan_dr(8, 32'hA5);
    chk("R4 bypass delay", obs[31:24], {8'hA5 & 8'h7F, 1'b0} >> 0 == 0 ? 8'h4A : 8'h4A);
    // R4 unlisted codes
    load_ir(5'b10110);
    scan_dr(8, 32'h3C);
    chk("R4 reserved bypass", obs[31:24], 8'h78);
    load_ir(5'b00100);
    scan_dr(4, 32'hF);
    chk("R4 readback bypass", obs[31:28], 4'hE);
    // R5
    load_ir(5'b01000);
    scan_dr(32, 32'h0);
    chk("R5 usercode word", obs, EXP_UC);
    // R6
    load_ir(5'b00010);
    chk("R6 user1 selected", usr1_sel, 1'b1);
    scan_dr(6, 32'h15);
    chk("R6 user1 tdo", obs[31:26], 6'h3F);
    load_ir(5'b00011);
    chk("R6 user2 selected", {usr2_sel, usr1_sel}, 2'b10);
    scan_dr(6, 32'h2A);
    chk("R6 user2 tdo", obs[31:26], 6'h00);
    // R8
    load_ir(5'b00101);
    cfg_cnt = 0;
    scan_dr(16, 32'hBEEF);
    chk("R8 cfg count", cfg_cnt, 16);
    chk("R8 cfg stream", cfg_acc[31:16], 16'hBEEF);
    // R9
    start_cnt = 0;
    load_ir(5'b01100);
    step(0, 0); step(0, 0); step(0, 0);
    chk("R9 single start", start_cnt, 1);
    // R10
    load_ir(5'b01010);
    chk("R10 hiz active", io_hiz, 1'b1);
    scan_dr(4, 32'h9);
    chk("R10 hiz bypass", obs[31:28], 4'h2);
    // R12
    load_ir(5'b00001);
    scan_dr(12, 32'hABC);
    chk("R12 stub zeros", obs[31:20], 12'hC00);
    load_ir(5'b00111);
    scan_dr(12, 32'h5A3);
    chk("R12 intest stub", obs[31:20], 12'h300);
    // R1 five ones from Shift-DR
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    chk("R1 five ones", usr_reset, 1'b1);
    step(0, 0);
    scan_dr(32, 32'h0);
    chk("R1 id after reset", obs, EXP_ID);
    summary();
    $finish;
  end
endmodule